// File: doc/BRIEF.md
# Pixel Tile Fetch Engine

This block is a bus master that pulls square pixel tiles out of system memory and deposits them in the input RAM of a transform engine. Software programs a source address, a row stride (the image width in bytes) and a tile count, then issues a start command. For each tile the engine reads eight rows of eight bytes. Each row is fetched as one two-beat incrementing burst. Every returned word goes straight to the input RAM through dedicated write data, address and enable outputs. The engine then hands the tile to the transform engine with a one-cycle launch pulse and watches the engine's busy flag.

The input RAM is split into two tile slots. While the transform engine works on one slot, the fetch engine drops its bus request for a cycle so other masters can win arbitration. It then fills the other slot. Launches wait until the transform engine has gone idle. After the final tile has been launched, the engine stays active until busy falls, and only then returns to idle. A stop command lets the tile in flight finish and be launched, and no further tiles are fetched. Software still reads the transform results from the output memory on its own.

Top module: `tile_fetch_dma`

## Requirements
- R1: After reset, m_cyc, m_stb, ram_we and dct_go are low, and the control register (word offset 2) reads with bit 0 (active) at 0.
- R2: Word offset 0 holds the source address and word offset 1 holds the row stride in bytes. Both read back exactly as written.
- R3: Writing the control register with bit 0 set starts a run of N tiles, where N is taken from bits 31:16. Tile b, row r, word w (r 0..7, w 0..1) is read from source + 8*b + r*stride + 4*w. The reads occur in the order b, then r, then w.
- R4: m_cti is 3'b010 (incrementing burst) on the first word of each row and 3'b111 (end of burst) on the last word of each row.
- R5: Each acknowledged read produces exactly one RAM write in the following cycle. The write data is the returned word, and the write address is {slot, r, w}, where the slot is the top bit.
- R6: dct_go is high for exactly one cycle per tile. It rises only while dct_busy is low, and only after all 16 words of that tile have been written.
- R7: Tiles alternate between slots starting with slot 0. dct_bank shows the slot of the tile being launched.
- R8: The fetch of the next tile proceeds while the transform engine is busy. m_cyc goes low between tiles, so it rises once per tile.
- R9: After the last tile is launched, the active bit stays 1 until dct_busy has fallen. The block then returns to idle.
- R10: A control write with bit 1 set during a run completes and launches the tile being fetched, then ends the run with no further reads.
- R11: A start command while a run is active has no effect. A start command with a count of 0 is ignored.
- R12: m_stb is never high while m_cyc is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_cyc | input | 1 | Register port cycle |
| s_stb | input | 1 | Register port strobe |
| s_we | input | 1 | Register port write enable |
| s_adr | input | 2 | Register word offset |
| s_dat_w | input | 32 | Register write data |
| s_dat_r | output | 32 | Register read data |
| s_ack | output | 1 | Register port acknowledge |
| m_cyc | output | 1 | Master bus cycle |
| m_stb | output | 1 | Master strobe |
| m_cti | output | 3 | Master cycle type |
| m_adr | output | 32 | Master byte address |
| m_dat_r | input | 32 | Master read data |
| m_ack | input | 1 | Master acknowledge |
| ram_wdata | output | 32 | Input RAM write data |
| ram_addr | output | 5 | Input RAM word address (slot, row, word) |
| ram_we | output | 1 | Input RAM write enable |
| dct_go | output | 1 | One-cycle transform launch |
| dct_bank | output | 1 | Slot of the launched tile |
| dct_busy | input | 1 | Transform engine busy |

## Verification
The assertions assume three things about the inputs. The memory acknowledges only a strobed read. dct_busy rises only in the cycle after a launch pulse and later falls by itself. Register accesses are single, fully handshaken transfers. The bench's memory model answers every strobe in the next cycle and then withholds its acknowledge for one cycle. Its transform model raises busy exactly one cycle after each launch and holds it for a fixed count longer than one tile fetch. This makes launches really wait on busy, and it makes fetches overlap the transform. Register writes always wait for the acknowledge before dropping the strobe.

// File: rtl/tfd_pkg.sv
package tfd_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_HANDOFF,
    S_FINAL,
    S_YIELD
  } fsm_t;

  localparam logic [2:0] CTI_CLASSIC = 3'b000;
  localparam logic [2:0] CTI_INCR    = 3'b010;
  localparam logic [2:0] CTI_END     = 3'b111;
endpackage

// File: rtl/tfd_regs.sv
module tfd_regs #(
  parameter int DW   = 32,
  parameter int CNTW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            s_cyc,
  input  logic            s_stb,
  input  logic            s_we,
  input  logic [1:0]      s_adr,
  input  logic [DW-1:0]   s_dat_w,
  output logic [DW-1:0]   s_dat_r,
  output logic            s_ack,
  output logic [DW-1:0]   src_o,
  output logic [DW-1:0]   stride_o,
  output logic [CNTW-1:0] count_o,
  output logic            start_o,
  output logic            stop_o,
  input  logic            active_i,
  input  logic [CNTW-1:0] remain_i
);
  logic          hit;
  logic [DW-1:0] rd_mux;

  assign hit = s_cyc && s_stb && !s_ack;

  always_comb begin
    case (s_adr)
      2'd0:    rd_mux = src_o;
      2'd1:    rd_mux = stride_o;
      2'd2:    rd_mux = {16'(remain_i), 15'b0, active_i};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_ack    <= 1'b0;
      s_dat_r  <= '0;
      src_o    <= '0;
      stride_o <= '0;
      count_o  <= '0;
      start_o  <= 1'b0;
      stop_o   <= 1'b0;
    end else begin
      s_ack   <= hit;
      start_o <= 1'b0;
      stop_o  <= 1'b0;
      if (hit) begin
        s_dat_r <= rd_mux;
        if (s_we) begin
          case (s_adr)
            2'd0: src_o    <= s_dat_w;
            2'd1: stride_o <= s_dat_w;
            2'd2: begin
              start_o <= s_dat_w[0];
              stop_o  <= s_dat_w[1];
              count_o <= s_dat_w[16 +: CNTW];
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/tfd_fetch.sv
module tfd_fetch
  import tfd_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int ROWS = 8,
  parameter int WPR  = 2,
  parameter int CNTW = 16,
  localparam int WORDS = ROWS * WPR,
  localparam int IDXW  = $clog2(WORDS),
  localparam int WSEL  = (WPR > 1) ? $clog2(WPR) : 1,
  localparam int BPW   = DW / 8,
  localparam int ROW_BYTES = WPR * BPW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   src_i,
  input  logic [AW-1:0]   stride_i,
  input  logic [CNTW-1:0] count_i,
  input  logic            start_i,
  input  logic            stop_i,
  output logic            active_o,
  output logic [CNTW-1:0] remain_o,
  output logic            m_cyc,
  output logic            m_stb,
  output logic [2:0]      m_cti,
  output logic [AW-1:0]   m_adr,
  input  logic [DW-1:0]   m_dat_r,
  input  logic            m_ack,
  output logic [DW-1:0]   ram_wdata,
  output logic [IDXW:0]   ram_addr,
  output logic            ram_we,
  output logic            dct_go,
  output logic            dct_bank,
  input  logic            dct_busy
);
  localparam logic [2:0] CTI_FIRST = (WPR == 1) ? CTI_END : CTI_INCR;

  fsm_t          state;
  logic [IDXW-1:0] idx;
  logic [WSEL-1:0] wcol;
  logic [AW-1:0] row_addr, blk_addr;
  logic          bank, stop_req, launched;
  logic          row_end, tile_end, last_tile, can_launch;
  logic [WSEL-1:0] wcol_nx;

  assign row_end    = (wcol == WSEL'(WPR - 1));
  assign tile_end   = (idx == IDXW'(WORDS - 1));
  assign last_tile  = (remain_o == CNTW'(1)) || stop_req || stop_i;
  assign can_launch = !dct_busy && !dct_go;
  assign wcol_nx    = row_end ? '0 : wcol + 1'b1;
  assign active_o   = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      idx       <= '0;
      wcol      <= '0;
      row_addr  <= '0;
      blk_addr  <= '0;
      bank      <= 1'b0;
      stop_req  <= 1'b0;
      launched  <= 1'b0;
      remain_o  <= '0;
      m_cyc     <= 1'b0;
      m_stb     <= 1'b0;
      m_cti     <= CTI_CLASSIC;
      m_adr     <= '0;
      ram_wdata <= '0;
      ram_addr  <= '0;
      ram_we    <= 1'b0;
      dct_go    <= 1'b0;
      dct_bank  <= 1'b0;
    end else begin
      ram_we <= 1'b0;
      dct_go <= 1'b0;
      if (stop_i && state != S_IDLE) stop_req <= 1'b1;
      case (state)
        S_IDLE: begin
          stop_req <= 1'b0;
          if (start_i && count_i != '0) begin
            blk_addr <= src_i;
            row_addr <= src_i;
            m_adr    <= src_i;
            remain_o <= count_i;
            bank     <= 1'b0;
            idx      <= '0;
            wcol     <= '0;
            m_cti    <= CTI_FIRST;
            m_cyc    <= 1'b1;
            m_stb    <= 1'b1;
            state    <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (m_ack) begin
            ram_we    <= 1'b1;
            ram_wdata <= m_dat_r;
            ram_addr  <= {bank, idx};
            idx       <= idx + 1'b1;
            wcol      <= wcol_nx;
            m_cti     <= (wcol_nx == WSEL'(WPR - 1)) ? CTI_END : CTI_INCR;
            if (row_end) begin
              row_addr <= row_addr + stride_i;
              m_adr    <= row_addr + stride_i;
            end else begin
              m_adr    <= m_adr + AW'(BPW);
            end
            if (tile_end) begin
              m_cyc    <= 1'b0;
              m_stb    <= 1'b0;
              m_cti    <= CTI_CLASSIC;
              remain_o <= remain_o - 1'b1;
              launched <= 1'b0;
              state    <= last_tile ? S_FINAL : S_HANDOFF;
            end
          end
        end
        S_HANDOFF: begin
          if (stop_req) begin
            state <= S_FINAL;
          end else if (can_launch) begin
            dct_go   <= 1'b1;
            dct_bank <= bank;
            bank     <= ~bank;
            state    <= S_YIELD;
          end
        end
        S_YIELD: begin
          if (stop_req) begin
            launched <= 1'b1;
            state    <= S_FINAL;
          end else begin
            blk_addr <= blk_addr + AW'(ROW_BYTES);
            row_addr <= blk_addr + AW'(ROW_BYTES);
            m_adr    <= blk_addr + AW'(ROW_BYTES);
            idx      <= '0;
            wcol     <= '0;
            m_cti    <= CTI_FIRST;
            m_cyc    <= 1'b1;
            m_stb    <= 1'b1;
            state    <= S_FETCH;
          end
        end
        S_FINAL: begin
          if (can_launch) begin
            if (!launched) begin
              dct_go   <= 1'b1;
              dct_bank <= bank;
              bank     <= ~bank;
              launched <= 1'b1;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tile_fetch_dma.sv
module tile_fetch_dma #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int ROWS = 8,
  parameter int WPR  = 2,
  parameter int CNTW = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       s_cyc,
  input  logic                       s_stb,
  input  logic                       s_we,
  input  logic [1:0]                 s_adr,
  input  logic [DW-1:0]              s_dat_w,
  output logic [DW-1:0]              s_dat_r,
  output logic                       s_ack,
  output logic                       m_cyc,
  output logic                       m_stb,
  output logic [2:0]                 m_cti,
  output logic [AW-1:0]              m_adr,
  input  logic [DW-1:0]              m_dat_r,
  input  logic                       m_ack,
  output logic [DW-1:0]              ram_wdata,
  output logic [$clog2(ROWS*WPR):0]  ram_addr,
  output logic                       ram_we,
  output logic                       dct_go,
  output logic                       dct_bank,
  input  logic                       dct_busy
);
  logic [DW-1:0]   src, stride;
  logic [CNTW-1:0] count, remain;
  logic            start_cmd, stop_cmd, active;

  tfd_regs #(.DW(DW), .CNTW(CNTW)) regs_i (
    .clk(clk), .rst(rst),
    .s_cyc(s_cyc), .s_stb(s_stb), .s_we(s_we), .s_adr(s_adr),
    .s_dat_w(s_dat_w), .s_dat_r(s_dat_r), .s_ack(s_ack),
    .src_o(src), .stride_o(stride), .count_o(count),
    .start_o(start_cmd), .stop_o(stop_cmd),
    .active_i(active), .remain_i(remain)
  );

  tfd_fetch #(.AW(AW), .DW(DW), .ROWS(ROWS), .WPR(WPR), .CNTW(CNTW)) fetch_i (
    .clk(clk), .rst(rst),
    .src_i(AW'(src)), .stride_i(AW'(stride)), .count_i(count),
    .start_i(start_cmd), .stop_i(stop_cmd),
    .active_o(active), .remain_o(remain),
    .m_cyc(m_cyc), .m_stb(m_stb), .m_cti(m_cti), .m_adr(m_adr),
    .m_dat_r(m_dat_r), .m_ack(m_ack),
    .ram_wdata(ram_wdata), .ram_addr(ram_addr), .ram_we(ram_we),
    .dct_go(dct_go), .dct_bank(dct_bank), .dct_busy(dct_busy)
  );
endmodule

// File: rtl/tfd_checker.sv
module tfd_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          m_cyc,
  input logic          m_stb,
  input logic          m_ack,
  input logic [2:0]    m_cti,
  input logic [AW-1:0] m_adr,
  input logic          ram_we,
  input logic          dct_go,
  input logic          dct_busy
);
  assert_stb_in_cyc_R12: assert property (@(posedge clk) disable iff (rst)
    m_stb |-> m_cyc);

  assert_go_single_R6: assert property (@(posedge clk) disable iff (rst)
    dct_go |=> !dct_go);

  assert_go_when_free_R6: assert property (@(posedge clk) disable iff (rst)
    dct_go |-> !dct_busy);

  assert_write_follows_ack_R5: assert property (@(posedge clk) disable iff (rst)
    (m_cyc && m_stb && m_ack) |=> ram_we);

  assert_adr_held_R3: assert property (@(posedge clk) disable iff (rst)
    (m_stb && !m_ack) |=> (m_stb && $stable(m_adr)));

  assert_cti_legal_R4: assert property (@(posedge clk) disable iff (rst)
    m_stb |-> (m_cti == 3'b010 || m_cti == 3'b111));
endmodule

bind tile_fetch_dma tfd_checker #(.AW(AW)) chk_i (
  .clk(clk), .rst(rst), .m_cyc(m_cyc), .m_stb(m_stb), .m_ack(m_ack),
  .m_cti(m_cti), .m_adr(m_adr), .ram_we(ram_we), .dct_go(dct_go),
  .dct_busy(dct_busy)
);

// File: tb/tile_fetch_dma_tb_top.sv
module tile_fetch_dma_tb_top;
  localparam int BUSYLEN = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        s_cyc = 0, s_stb = 0, s_we = 0;
  logic [1:0]  s_adr = '0;
  logic [31:0] s_dat_w = '0;
  logic [31:0] s_dat_r;
  logic        s_ack;
  logic        m_cyc, m_stb;
  logic [2:0]  m_cti;
  logic [31:0] m_adr;
  logic [31:0] m_dat_r;
  logic        m_ack;
  logic [31:0] ram_wdata;
  logic [4:0]  ram_addr;
  logic        ram_we, dct_go, dct_bank, dct_busy;
  int          busy_cnt;

  int checks = 0, errors = 0;

  logic [31:0] adr_log [128];
  logic [2:0]  cti_log [128];
  logic [31:0] wd_log  [128];
  logic [4:0]  wa_log  [128];
  logic        gb_log  [16];
  int          gw_log  [16];
  int n_ack, n_wr, n_go, n_rise, n_stb_bad;
  bit overlap, prev_cyc;

  always #5 clk = ~clk;

  tile_fetch_dma dut_i (
    .clk(clk), .rst(rst),
    .s_cyc(s_cyc), .s_stb(s_stb), .s_we(s_we), .s_adr(s_adr),
    .s_dat_w(s_dat_w), .s_dat_r(s_dat_r), .s_ack(s_ack),
    .m_cyc(m_cyc), .m_stb(m_stb), .m_cti(m_cti), .m_adr(m_adr),
    .m_dat_r(m_dat_r), .m_ack(m_ack),
    .ram_wdata(ram_wdata), .ram_addr(ram_addr), .ram_we(ram_we),
    .dct_go(dct_go), .dct_bank(dct_bank), .dct_busy(dct_busy)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0] ^ 16'hBEEF, a[15:0]};
  endfunction

  // memory model: answers a strobe in the next cycle, then idles one cycle
  always @(posedge clk) begin
    if (rst) begin
      m_ack   <= 1'b0;
      m_dat_r <= '0;
    end else if (m_cyc && m_stb && !m_ack) begin
      m_ack   <= 1'b1;
      m_dat_r <= mem_word(m_adr);
    end else begin
      m_ack   <= 1'b0;
    end
  end

  // transform engine model: busy from the cycle after a launch
  always @(posedge clk) begin
    if (rst) busy_cnt <= 0;
    else if (dct_go) busy_cnt <= BUSYLEN;
    else if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
  end
  assign dct_busy = (busy_cnt != 0);

  // observation at the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      if (m_cyc && m_stb && m_ack && n_ack < 128) begin
        adr_log[n_ack] <= m_adr;
        cti_log[n_ack] <= m_cti;
        n_ack <= n_ack + 1;
        if (dct_busy) overlap <= 1'b1;
      end
      if (ram_we && n_wr < 128) begin
        wd_log[n_wr] <= ram_wdata;
        wa_log[n_wr] <= ram_addr;
        n_wr <= n_wr + 1;
      end
      if (dct_go && n_go < 16) begin
        gb_log[n_go] <= dct_bank;
        gw_log[n_go] <= n_wr;
        n_go <= n_go + 1;
      end
      if (m_cyc && !prev_cyc) n_rise <= n_rise + 1;
      if (m_stb && !m_cyc) n_stb_bad <= n_stb_bad + 1;
      prev_cyc <= m_cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    n_ack = 0; n_wr = 0; n_go = 0; n_rise = 0; overlap = 1'b0;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    s_cyc = 1; s_stb = 1; s_we = 1; s_adr = a; s_dat_w = d;
    @(negedge clk);
    while (!s_ack) @(negedge clk);
    s_cyc = 0; s_stb = 0; s_we = 0;
    @(negedge clk);
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    s_cyc = 1; s_stb = 1; s_we = 0; s_adr = a;
    @(negedge clk);
    while (!s_ack) @(negedge clk);
    d = s_dat_r;
    s_cyc = 0; s_stb = 0;
    @(negedge clk);
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] st;
    int n = 0;
    reg_read(2'd2, st);
    while (st[0] && n < 3000) begin
      reg_read(2'd2, st);
      n++;
    end
    chk(st[0] == 1'b0, req, st, 0);
  endtask

  task automatic verify_run(input logic [31:0] base, input logic [31:0] stride, input int nblk);
    chk(n_ack == nblk * 16, "R3", n_ack, nblk * 16);
    chk(n_wr == nblk * 16, "R5", n_wr, nblk * 16);
    for (int k = 0; k < nblk * 16 && k < 128; k++) begin
      int b, i, r, w;
      logic [31:0] ea;
      b = k / 16; i = k % 16; r = i / 2; w = i % 2;
      ea = base + 32'(b * 8) + 32'(r) * stride + 32'(4 * w);
      chk(adr_log[k] == ea, "R3", adr_log[k], ea);
      chk(cti_log[k] == ((w == 1) ? 3'b111 : 3'b010), "R4", 32'(cti_log[k]), (w == 1) ? 7 : 2);
      chk(wa_log[k] == {1'(b % 2), 4'(i)}, "R5", 32'(wa_log[k]), 32'({1'(b % 2), 4'(i)}));
      chk(wd_log[k] == mem_word(ea), "R5", wd_log[k], mem_word(ea));
    end
    chk(n_go == nblk, "R6", n_go, nblk);
    for (int g = 0; g < nblk && g < 16; g++) begin
      chk(gw_log[g] == 16 * (g + 1), "R6", gw_log[g], 16 * (g + 1));
      chk(gb_log[g] == 1'(g % 2), "R7", 32'(gb_log[g]), g % 2);
    end
    chk(n_rise == nblk, "R8", n_rise, nblk);
  endtask

  task automatic t_reset();
    logic [31:0] st;
    chk(!m_cyc && !m_stb, "R1", {m_cyc, m_stb}, 0);
    chk(!ram_we && !dct_go, "R1", {ram_we, dct_go}, 0);
    reg_read(2'd2, st);
    chk(st[0] == 1'b0, "R1", st, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    reg_write(2'd0, 32'h0000_1000);
    reg_write(2'd1, 32'h0000_0040);
    reg_read(2'd0, v);
    chk(v == 32'h1000, "R2", v, 32'h1000);
    reg_read(2'd1, v);
    chk(v == 32'h40, "R2", v, 32'h40);
  endtask

  task automatic t_single();
    logic [31:0] st;
    clear_logs();
    reg_write(2'd2, {16'd1, 16'h0001});
    @(negedge clk);
    while (!dct_go) @(negedge clk);
    reg_read(2'd2, st);
    chk(st[0] == 1'b1 && dct_busy, "R9", {st[0], dct_busy}, 3);
    wait_idle("R9");
    chk(!dct_busy, "R9", dct_busy, 0);
    verify_run(32'h1000, 32'h40, 1);
  endtask

  task automatic t_multi();
    reg_write(2'd0, 32'h0000_2000);
    reg_write(2'd1, 32'h0000_0100);
    clear_logs();
    reg_write(2'd2, {16'd3, 16'h0001});
    wait_idle("R9");
    verify_run(32'h2000, 32'h100, 3);
    chk(overlap, "R8", overlap, 1);
  endtask

  task automatic t_stop();
    clear_logs();
    reg_write(2'd2, {16'd5, 16'h0001});
    @(negedge clk);
    while (!dct_go) @(negedge clk);
    reg_write(2'd2, 32'h0000_0002);
    wait_idle("R10");
    verify_run(32'h2000, 32'h100, 2);
  endtask

  task automatic t_ignored();
    logic [31:0] st;
    clear_logs();
    reg_write(2'd2, {16'd2, 16'h0001});
    reg_write(2'd2, {16'd9, 16'h0001});
    wait_idle("R11");
    chk(n_go == 2, "R11", n_go, 2);
    chk(n_ack == 32, "R11", n_ack, 32);
    clear_logs();
    reg_write(2'd2, {16'd0, 16'h0001});
    repeat (10) @(negedge clk);
    reg_read(2'd2, st);
    chk(st[0] == 1'b0, "R11", st, 0);
    chk(n_rise == 0 && n_ack == 0, "R11", n_rise, 0);
  endtask

  initial begin
    n_ack = 0; n_wr = 0; n_go = 0; n_rise = 0; n_stb_bad = 0;
    overlap = 0; prev_cyc = 0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_single();
    t_multi();
    t_stop();
    t_ignored();
    chk(n_stb_bad == 0, "R12", n_stb_bad, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R9 watchdog actual=running expected=idle");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule